// File: doc/BRIEF.md
# DMA Channel Run-Control Register

This block holds the run-control and status word of one DMA channel. Software drives the channel through a 32-bit register port. A write to the control offset carries a per-bit select mask in its upper half and the new values in its lower half. Only selected bits change, and only the bits that software owns. A read of the status offset returns the live status word. Words are little-endian: bit 0 is the least significant bit of byte 0.

The command engine owns some flags. It raises and drops ACTIVE, raises DEAD, sets and clears the branch-taken flag, and updates the device status byte. It also reports when a flush has drained and when a wake has been taken, and the block then clears those requests by itself. The run, pause, flush and wake flags go straight out to the engine as levels.

Two polled software handshakes rest on this block:
- **Stop:** clear RUN and FLUSH in one write, then poll until ACTIVE and FLUSH both read zero.
- **Reset:** clear the six control flags in one write, then poll until RUN reads zero.

Top module: `dmaRunCtl`

## Requirements
- R1: After reset the status word reads 0x0000 and the run, pause, flush and wake outputs are low.
- R2: A control write (offset 0) changes status bit k to write-data bit k only where write-data bit 16+k is 1. This applies to the software-owned bits: RUN (bit 15), PAUSE (bit 14), FLUSH (bit 13), WAKE (bit 12) and device status (bits 7:0). The new value is visible one cycle after the write. Unselected bits keep their value.
- R3: ACTIVE (bit 10) and branch-taken BT (bit 8) ignore control writes. BT is set by `btSet` and cleared by `btClr`, and clear wins. ACTIVE is set by `actSet` only while RUN is 1, and cleared by `actClr`.
- R4: DEAD (bit 11) is set by `deadSet`. A control write clears it only if it is a reset request: write-data bits 31:26 all 1 and bits 15:10 all 0. A reset request also clears RUN, PAUSE, FLUSH and WAKE, and it wins over `deadSet`. Any other write to bit 11 is ignored.
- R5: A stop request (select bits 29 and 31 set, value bits 13 and 15 clear) leaves RUN and FLUSH at 0 in the next cycle.
- R6: If RUN is 0 and `beatBusy` is 0 in a cycle, ACTIVE is 0 in the next cycle. While `beatBusy` stays 1, ACTIVE holds.
- R7: `flushDone` clears FLUSH and `wakeDone` clears WAKE in the next cycle. A control write that selects the same bit in the same cycle wins.
- R8: Device status bit k is set by `devSet[k]` and cleared by `devClr[k]`, and set wins. A control write selecting bit k wins over both.
- R9: Reads are combinational. Offset 1 returns the status word with bits 31:16 and bit 9 at zero. Offset 0 and any other offset read zero. Bit 9 cannot be written.
- R10: `runOut`, `pauseOut`, `flushOut` and `wakeOut` equal status bits 15, 14, 13 and 12 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Word offset (0 control, 1 status) |
| regWrData | input | 32 | Write data: select mask in 31:16, values in 15:0 |
| regRdData | output | 32 | Read data for `regAddr` |
| beatBusy | input | 1 | A bus beat of the engine is in progress |
| actSet | input | 1 | Engine sets ACTIVE |
| actClr | input | 1 | Engine clears ACTIVE |
| deadSet | input | 1 | Engine sets DEAD |
| btSet | input | 1 | Engine sets branch-taken |
| btClr | input | 1 | Engine clears branch-taken |
| devSet | input | DEV_W | Device status bits to set |
| devClr | input | DEV_W | Device status bits to clear |
| flushDone | input | 1 | Engine has drained pending data |
| wakeDone | input | 1 | Engine has resumed after a wake |
| runOut | output | 1 | RUN level to the engine |
| pauseOut | output | 1 | PAUSE level to the engine |
| flushOut | output | 1 | FLUSH level to the engine |
| wakeOut | output | 1 | WAKE level to the engine |

## Verification
The assertions assume the engine pulses are well-behaved. `flushDone` and `wakeDone` are taken as one-cycle events. `beatBusy` eventually falls after RUN is cleared, so the bound on ACTIVE is counted from the cycle the beat ends rather than from the stop write. The bench keeps to this. It drives every input at the falling edge and holds all engine inputs idle during the mask-and-value sweep. It raises `beatBusy` only around the stop sequence, and it drops it before polling for ACTIVE.

// File: rtl/dmarc_pkg.sv
package dmarc_pkg;
  // Status bit positions; the engine and software polls decode these.
  localparam int BIT_RUN    = 15;
  localparam int BIT_PAUSE  = 14;
  localparam int BIT_FLUSH  = 13;
  localparam int BIT_WAKE   = 12;
  localparam int BIT_DEAD   = 11;
  localparam int BIT_ACTIVE = 10;
  localparam int BIT_BT     = 8;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 32;

  // Bits 15:10 all selected and all zero form a reset request.
  localparam logic [HALF_W-1:0] RESET_SEL = 16'hFC00;

  typedef struct packed {
    logic              wr;
    logic              rstReq;
    logic [HALF_W-1:0] sel;
    logic [HALF_W-1:0] val;
  } ctlStrobe_t;
endpackage

// File: rtl/dmarcCtl.sv
module dmarcCtl
  import dmarc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_IDX = 0,
  parameter int STAT_IDX = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [HALF_W-1:0] statusWord,
  output ctlStrobe_t        strobe,
  output logic [WORD_W-1:0] regRdData
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);

  logic ctrlHit;
  logic [HALF_W-1:0] selPart;
  logic [HALF_W-1:0] valPart;

  assign ctrlHit = regWrEn && (regAddr == CTRL_A);
  assign selPart = regWrData[WORD_W-1:HALF_W];
  assign valPart = regWrData[HALF_W-1:0];

  always_comb begin
    strobe.wr     = ctrlHit;
    strobe.sel    = selPart;
    strobe.val    = valPart;
    strobe.rstReq = ctrlHit
                    && ((selPart & RESET_SEL) == RESET_SEL)
                    && ((valPart & RESET_SEL) == '0);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == STAT_A) begin
      regRdData[HALF_W-1:0] = statusWord;
    end
  end

  // R9: the upper half and bit 9 never read back as one.
  p_rd_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[WORD_W-1:HALF_W] == '0) && !regRdData[9]);
endmodule

// File: rtl/dmarcData.sv
module dmarcData
  import dmarc_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              beatBusy,
  input  logic              actSet,
  input  logic              actClr,
  input  logic              deadSet,
  input  logic              btSet,
  input  logic              btClr,
  input  logic [DEV_W-1:0]  devSet,
  input  logic [DEV_W-1:0]  devClr,
  input  logic              flushDone,
  input  logic              wakeDone,
  output logic [HALF_W-1:0] statusWord
);
  logic run, pause, flush, wake, dead, active, bt;
  logic runN, pauseN, flushN, wakeN, deadN, activeN, btN;
  logic [DEV_W-1:0] dev, devN;

  function automatic logic swPick(input logic cur, input int idx, input ctlStrobe_t s);
    return (s.wr && s.sel[idx]) ? s.val[idx] : cur;
  endfunction

  always_comb begin
    runN   = swPick(run, BIT_RUN, strobe);
    pauseN = swPick(pause, BIT_PAUSE, strobe);
    flushN = swPick(flush && !flushDone, BIT_FLUSH, strobe);
    wakeN  = swPick(wake && !wakeDone, BIT_WAKE, strobe);
    if (strobe.rstReq) begin
      runN = 1'b0; pauseN = 1'b0; flushN = 1'b0; wakeN = 1'b0;
    end
    deadN = (dead || deadSet) && !strobe.rstReq;
    activeN = active;
    if (run && actSet) activeN = 1'b1;
    if (actClr) activeN = 1'b0;
    if (!run && !beatBusy) activeN = 1'b0;
    btN = (bt || btSet) && !btClr;
  end

  // Device status: one lane per bit; engine set beats clear, software beats both.
  for (genvar k = 0; k < DEV_W; k++) begin : g_dev
    logic hwNext;
    assign hwNext  = devSet[k] || (dev[k] && !devClr[k]);
    assign devN[k] = (strobe.wr && strobe.sel[k]) ? strobe.val[k] : hwNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run <= 1'b0; pause <= 1'b0; flush <= 1'b0; wake <= 1'b0;
      dead <= 1'b0; active <= 1'b0; bt <= 1'b0; dev <= '0;
    end else begin
      run <= runN; pause <= pauseN; flush <= flushN; wake <= wakeN;
      dead <= deadN; active <= activeN; bt <= btN; dev <= devN;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BIT_RUN]    = run;
    statusWord[BIT_PAUSE]  = pause;
    statusWord[BIT_FLUSH]  = flush;
    statusWord[BIT_WAKE]   = wake;
    statusWord[BIT_DEAD]   = dead;
    statusWord[BIT_ACTIVE] = active;
    statusWord[BIT_BT]     = bt;
    statusWord[DEV_W-1:0]  = dev;
  end

  // R6: an idle bus with RUN low retires ACTIVE on the next edge.
  p_active_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    active && !run && !beatBusy |=> !active);
  // R3: a control write alone never moves BT.
  p_bt_write_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr && !btSet && !btClr |=> $stable(bt));
  // R4: DEAD moves only on an engine set or a reset request.
  p_dead_owned_r4: assert property (@(posedge clk) disable iff (!rstN)
    !deadSet && !strobe.rstReq |=> $stable(dead));
  // R5: a stop request leaves RUN and FLUSH low.
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr && strobe.sel[BIT_RUN] && strobe.sel[BIT_FLUSH]
      && !strobe.val[BIT_RUN] && !strobe.val[BIT_FLUSH] |=> !run && !flush);
  // R7: a drained flush clears unless software selects FLUSH that cycle.
  p_flush_self_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushDone && !(strobe.wr && strobe.sel[BIT_FLUSH]) |=> !flush);
  // R4: after a reset request the control flags are all low.
  p_reset_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstReq |=> !run && !pause && !flush && !wake && !dead);
endmodule

// File: rtl/dmaRunCtl.sv
module dmaRunCtl
  import dmarc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              beatBusy,
  input  logic              actSet,
  input  logic              actClr,
  input  logic              deadSet,
  input  logic              btSet,
  input  logic              btClr,
  input  logic [DEV_W-1:0]  devSet,
  input  logic [DEV_W-1:0]  devClr,
  input  logic              flushDone,
  input  logic              wakeDone,
  output logic              runOut,
  output logic              pauseOut,
  output logic              flushOut,
  output logic              wakeOut
);
  ctlStrobe_t        strobe;
  logic [HALF_W-1:0] statusWord;

  dmarcCtl #(.ADDR_W(ADDR_W), .CTRL_IDX(0), .STAT_IDX(1)) uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .statusWord(statusWord),
    .strobe(strobe), .regRdData(regRdData)
  );

  dmarcData #(.DEV_W(DEV_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatBusy(beatBusy),
    .actSet(actSet), .actClr(actClr), .deadSet(deadSet),
    .btSet(btSet), .btClr(btClr), .devSet(devSet), .devClr(devClr),
    .flushDone(flushDone), .wakeDone(wakeDone), .statusWord(statusWord)
  );

  assign runOut   = statusWord[BIT_RUN];
  assign pauseOut = statusWord[BIT_PAUSE];
  assign flushOut = statusWord[BIT_FLUSH];
  assign wakeOut  = statusWord[BIT_WAKE];
endmodule

// File: tb/sim_dmaRunCtl.sv
`timescale 1ns/1ps
module sim_dmaRunCtl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd1;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic beatBusy = 1'b0, actSet = 1'b0, actClr = 1'b0, deadSet = 1'b0;
  logic btSet = 1'b0, btClr = 1'b0, flushDone = 1'b0, wakeDone = 1'b0;
  logic [7:0] devSet = '0, devClr = '0;
  logic runOut, pauseOut, flushOut, wakeOut;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmaRunCtl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .beatBusy(beatBusy),
    .actSet(actSet), .actClr(actClr), .deadSet(deadSet), .btSet(btSet),
    .btClr(btClr), .devSet(devSet), .devClr(devClr), .flushDone(flushDone),
    .wakeDone(wakeDone), .runOut(runOut), .pauseOut(pauseOut),
    .flushOut(flushOut), .wakeOut(wakeOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readStat(output logic [31:0] w);
    regAddr = 4'd1;
    #1 w = regRdData;
  endtask

  task automatic ctlWrite(input logic [31:0] w);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = w;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'd1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic checkOuts(input string tag, input logic [15:0] e);
    check(tag, {28'd0, runOut, pauseOut, flushOut, wakeOut}, {28'd0, e[15:12]});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-reqs actual=hung expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] expW;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readStat(rd);
    check("R1 reset status", rd, 32'h0);
    checkOuts("R1 R10 reset outputs", 16'h0);

    // R2 R10: sweep the control-flag select and value nibbles with device bytes.
    expW = 16'h0;
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic [15:0] sel, val;
        sel = {4'(m), 4'h0, 8'((m * 37 + v * 11) & 8'hFF)};
        val = {4'(v), 4'h0, 8'((m * v * 13 + v) & 8'hFF)};
        ctlWrite({sel, val});
        expW = (expW & ~(sel & 16'hF0FF)) | (val & sel & 16'hF0FF);
        readStat(rd);
        check("R2 masked write", rd, {16'h0, expW});
        checkOuts("R10 outputs follow", expW);
      end
    end

    // R9: control offset reads zero; bit 9 not writable.
    ctlWrite(32'hFFFF_0000);
    ctlWrite(32'h0200_0200);
    regAddr = 4'd0; #1 check("R9 control reads zero", regRdData, 32'h0);
    regAddr = 4'd7; #1 check("R9 other offset zero", regRdData, 32'h0);
    readStat(rd);
    check("R9 bit 9 stays zero", rd, 32'h0);

    // R3: ACTIVE and BT ignore writes; ACTIVE needs RUN.
    pulse(actSet);
    readStat(rd);
    check("R3 active needs run", rd, 32'h0);
    ctlWrite(32'h8000_8000);
    pulse(actSet);
    pulse(btSet);
    readStat(rd);
    check("R3 engine sets active bt", rd, 32'h0000_8500);
    ctlWrite(32'h0500_0000);
    readStat(rd);
    check("R3 write clear ignored", rd, 32'h0000_8500);
    @(negedge clk); btSet = 1'b1; btClr = 1'b1;
    @(negedge clk); btSet = 1'b0; btClr = 1'b0;
    readStat(rd);
    check("R3 bt clear wins", rd, 32'h0000_8400);
    pulse(actClr);
    readStat(rd);
    check("R3 engine clears active", rd, 32'h0000_8000);

    // R5 R6: stop during a busy beat.
    pulse(actSet);
    ctlWrite(32'h2000_2000);
    @(negedge clk); beatBusy = 1'b1;
    ctlWrite(32'hA000_0000);
    @(negedge clk);
    readStat(rd);
    check("R5 stop clears run flush", rd, 32'h0000_0400);
    check("R6 active holds while busy", rd, 32'h0000_0400);
    beatBusy = 1'b0;
    @(negedge clk);
    readStat(rd);
    check("R6 active drops after beat", rd, 32'h0);

    // R7: self-clearing flush and wake, and write priority.
    ctlWrite(32'h3000_3000);
    pulse(flushDone);
    readStat(rd);
    check("R7 flush self clear", rd, 32'h0000_1000);
    pulse(wakeDone);
    readStat(rd);
    check("R7 wake self clear", rd, 32'h0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'h2000_2000; flushDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; flushDone = 1'b0;
    readStat(rd);
    check("R7 write beats flushDone", rd, 32'h0000_2000);
    pulse(flushDone);

    // R8: device status set/clear and software priority.
    @(negedge clk); devSet = 8'h0F; devClr = 8'h03;
    @(negedge clk); devSet = 8'h00; devClr = 8'h05;
    @(negedge clk); devClr = 8'h00;
    readStat(rd);
    check("R8 dev set wins then clear", rd, 32'h0000_000A);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'h00F0_0050; devSet = 8'hFF;
    @(negedge clk);
    regWrEn = 1'b0; devSet = 8'h00;
    readStat(rd);
    check("R8 write beats dev set", rd, 32'h0000_005F);

    // R4: DEAD ignores plain writes, cleared by a reset request.
    ctlWrite(32'hD000_D000);
    pulse(deadSet);
    ctlWrite(32'h0800_0000);
    readStat(rd);
    check("R4 dead write ignored", rd, 32'h0000_D85F);
    ctlWrite(32'hFC00_0000);
    readStat(rd);
    check("R4 reset request clears", rd, 32'h0000_005F);
    checkOuts("R4 R10 outputs after reset req", 16'h0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'hFC00_0000; deadSet = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; deadSet = 1'b0;
    readStat(rd);
    check("R4 reset beats deadSet", rd, 32'h0000_005F);

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule